// File: doc/BRIEF.md
# FIFO Interrupt and Threshold Controller

This block is the interrupt and watermark logic of a byte-oriented serial bus master. It sits between the transmit and receive byte FIFOs, the serial engine and the register interface. The FIFO storage and the engine are outside the block. They appear only as level inputs and as push and pop strobes. The block holds a FIFO control word with two direction enables and two trigger levels, and an interrupt-enable mask. It also holds a sticky interrupt-status vector that software clears by writing ones.

The block raises an almost-empty event on the transmit side and an almost-full event on the receive side. It flags an underrun or an overrun whenever a strobe hits an empty or a full FIFO. It raises a trailing event when a partly filled receive FIFO stays idle below its trigger for a programmable number of cycles. It merges five transfer-result pulses from the engine into the same status vector. A setup strobe loads the trigger level of the active direction with a default that depends on the message length. A packed word reports both FIFO levels and their full and empty flags.

There is no data stream at this boundary. Every port is a plain control or status pin, and no port applies back-pressure. All strobes are single-cycle pulses sampled at the rising clock edge.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset, `int_status`, `int_en`, `irq` and `ctrl_rdata` are all zero. With both levels at zero, `fifo_status` reads 32'h0100_0100.
- R2: Every status bit is sticky. A pulse on `ist_clr` clears exactly the bits set to one in `ist_wdata`. A bit whose set condition holds in the same cycle stays set.
- R3: Status bit 0 sets while the transmit enable is on and `tx_level` is less than or equal to the transmit trigger. Status bit 1 sets while the receive enable is on and `rx_level` is greater than or equal to the receive trigger.
- R4: A `xfer_setup` pulse with `xfer_rd`=1 loads the receive trigger. With `xfer_rd`=0 it loads the transmit trigger. The value loaded is 3/4 of DEPTH for a read, or 1/4 of DEPTH for a write, when `xfer_len` exceeds DEPTH. Otherwise the value loaded is `xfer_len`. The pulse takes priority over `ctrl_wr` for that trigger.
- R5: The status bits below are set when a strobe hits a FIFO in the wrong state.
  - Bit 2 (transmit underrun): `tx_pop` while `tx_level`=0.
  - Bit 3 (transmit overrun): `tx_push` while `tx_level`=DEPTH.
  - Bit 4 (receive underrun): `rx_pop` while `rx_level`=0.
  - Bit 5 (receive overrun): `rx_push` while `rx_level`=DEPTH.
  
  A strobe on a FIFO that is neither empty nor full sets nothing.
- R6: The pulses `ev_done`, `ev_abort`, `ev_nack`, `ev_nodev` and `ev_tmo` set status bits 7, 8, 9, 10 and 11.
- R7: The receive path is idle in a cycle when all of the following hold: the receive enable is on, 0 < `rx_level` < receive trigger, and there is no `rx_push` and no `rx_pop`. Status bit 6 (trailing) sets on the edge that closes idle cycle L+1, where L is the trailing limit. It sets once per idle stretch. Any non-idle cycle restarts the count.
- R8: `irq` is a register. It goes high one cycle after any status bit is both set and enabled in `int_en`. A set bit that is not enabled never raises `irq`.
- R9: The layout of `fifo_status` is as follows.

  | Bits | Content |
  |---|---|
  | 6:0 | `tx_level` |
  | 7 | transmit full |
  | 8 | transmit empty |
  | 22:16 | `rx_level` |
  | 23 | receive full |
  | 24 | receive empty |
  | all others | zero |
- R10: The layout of `ctrl_wdata` and `ctrl_rdata` is as follows.

  | Bits | Content |
  |---|---|
  | 0 | receive enable |
  | 1 | transmit enable |
  | 10:4 | receive trigger |
  | 22:16 | transmit trigger |

  The trailing limit is 4 bits wide, resets to 15 and is loaded by `trail_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the FIFO control word |
| ctrl_wdata | input | 32 | New FIFO control word |
| ctrl_rdata | output | 32 | Current FIFO control word |
| xfer_setup | input | 1 | Load the default trigger for a message |
| xfer_rd | input | 1 | Message direction: 1 = read, 0 = write |
| xfer_len | input | LEN_W | Message length in bytes |
| ien_wr | input | 1 | Write strobe for the interrupt-enable mask |
| ien_wdata | input | 12 | New interrupt-enable mask |
| ist_clr | input | 1 | Write-one-to-clear strobe for the status vector |
| ist_wdata | input | 12 | Bits to clear |
| trail_wr | input | 1 | Write strobe for the trailing limit |
| trail_wdata | input | TRAIL_W | New trailing limit |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_push | input | 1 | Register side writes a transmit byte |
| tx_pop | input | 1 | Engine takes a transmit byte |
| rx_push | input | 1 | Engine stores a receive byte |
| rx_pop | input | 1 | Register side reads a receive byte |
| ev_done | input | 1 | Transfer completed |
| ev_abort | input | 1 | Arbitration lost |
| ev_nack | input | 1 | Target did not acknowledge |
| ev_nodev | input | 1 | No device answered |
| ev_tmo | input | 1 | Transfer timed out |
| int_status | output | 12 | Sticky interrupt status |
| int_en | output | 12 | Interrupt-enable mask |
| fifo_status | output | 32 | Packed FIFO levels and flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The main instance is built with DEPTH=16. At that depth, 5-bit levels reach the full and empty edges with short stimulus. The equal-to-trigger boundaries of both watermarks fall inside a six-entry vector table. The default trailing limit of 15 can also be exercised in a few dozen cycles.

A second instance with DEPTH=64 runs in parallel. It shows that the length-dependent defaults scale with depth, to 48 for a read and 16 for a write. This covers the second supported depth value without a second test run.

// File: rtl/fifoirq_pkg.sv
package fifoirq_pkg;
  localparam int ST_W    = 12;
  localparam int FLD_W   = 7;
  localparam int B_TXAE  = 0;
  localparam int B_RXAF  = 1;
  localparam int B_TXUR  = 2;
  localparam int B_TXOR  = 3;
  localparam int B_RXUR  = 4;
  localparam int B_RXOR  = 5;
  localparam int B_TRAIL = 6;
  localparam int B_DONE  = 7;
  localparam int B_ABORT = 8;
  localparam int B_NACK  = 9;
  localparam int B_NODEV = 10;
  localparam int B_TMO   = 11;
  typedef logic [ST_W-1:0] irq_vec_t;
endpackage

// File: rtl/fit_thresh.sv
module fit_thresh #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [31:0]      ctrl_wdata,
  input  logic             setup,
  input  logic             setup_rd,
  input  logic [LEN_W-1:0] setup_len,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             tx_en,
  output logic             rx_en,
  output logic [LVL_W-1:0] tx_trig,
  output logic [LVL_W-1:0] rx_trig,
  output logic             almost_empty,
  output logic             almost_full
);
  localparam int RX_DEF = DEPTH * 3 / 4;
  localparam int TX_DEF = DEPTH / 4;

  logic             is_long;
  logic [LVL_W-1:0] rx_pick, tx_pick;
  logic             unused_ctrl;

  assign unused_ctrl = ^ctrl_wdata;
  assign is_long = setup_len > LEN_W'(DEPTH);
  assign rx_pick = is_long ? LVL_W'(RX_DEF) : setup_len[LVL_W-1:0];
  assign tx_pick = is_long ? LVL_W'(TX_DEF) : setup_len[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      tx_trig <= '0;
      rx_trig <= '0;
    end else begin
      if (ctrl_wr) begin
        rx_en   <= ctrl_wdata[0];
        tx_en   <= ctrl_wdata[1];
        rx_trig <= ctrl_wdata[4 +: LVL_W];
        tx_trig <= ctrl_wdata[16 +: LVL_W];
      end
      if (setup) begin
        if (setup_rd) rx_trig <= rx_pick;
        else          tx_trig <= tx_pick;
      end
    end
  end

  assign almost_empty = tx_en && (tx_level <= tx_trig);
  assign almost_full  = rx_en && (rx_level >= rx_trig);

  // R4
  rx_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && setup_rd && (setup_len > LEN_W'(DEPTH))) |=> (rx_trig == LVL_W'(RX_DEF)));
  // R4
  tx_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && !setup_rd && (setup_len > LEN_W'(DEPTH))) |=> (tx_trig == LVL_W'(TX_DEF)));
endmodule

// File: rtl/fit_flowerr.sv
module fit_flowerr #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             rx_push,
  input  logic             rx_pop,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic [3:0]       err
);
  assign tx_full  = tx_level == LVL_W'(DEPTH);
  assign tx_empty = tx_level == '0;
  assign rx_full  = rx_level == LVL_W'(DEPTH);
  assign rx_empty = rx_level == '0;

  // err order: {rx overrun, rx underrun, tx overrun, tx underrun}
  assign err = {rx_push && rx_full, rx_pop && rx_empty,
                tx_push && tx_full, tx_pop && tx_empty};
endmodule

// File: rtl/fit_trail.sv
module fit_trail #(
  parameter int LVL_W     = 5,
  parameter int TRAIL_W   = 4,
  parameter int TRAIL_DEF = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lim_wr,
  input  logic [TRAIL_W-1:0] lim_wdata,
  input  logic               rx_en,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   rx_trig,
  input  logic               rx_push,
  input  logic               rx_pop,
  output logic               fire
);
  logic [TRAIL_W-1:0] lim_q, cnt_q;
  logic               fired_q, idle;

  assign idle = rx_en && (rx_level != '0) && (rx_level < rx_trig) && !rx_push && !rx_pop;
  assign fire = idle && (cnt_q == lim_q) && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= TRAIL_W'(TRAIL_DEF);
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (lim_wr) lim_q <= lim_wdata;
      if (!idle) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (cnt_q == lim_q) begin
        fired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7
  trail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl import fifoirq_pkg::*; #(
  parameter int DEPTH     = 16,
  parameter int LEN_W     = 16,
  parameter int TRAIL_W   = 4,
  parameter int TRAIL_DEF = 15,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [31:0]        ctrl_wdata,
  output logic [31:0]        ctrl_rdata,
  input  logic               xfer_setup,
  input  logic               xfer_rd,
  input  logic [LEN_W-1:0]   xfer_len,
  input  logic               ien_wr,
  input  logic [ST_W-1:0]    ien_wdata,
  input  logic               ist_clr,
  input  logic [ST_W-1:0]    ist_wdata,
  input  logic               trail_wr,
  input  logic [TRAIL_W-1:0] trail_wdata,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               tx_push,
  input  logic               tx_pop,
  input  logic               rx_push,
  input  logic               rx_pop,
  input  logic               ev_done,
  input  logic               ev_abort,
  input  logic               ev_nack,
  input  logic               ev_nodev,
  input  logic               ev_tmo,
  output logic [ST_W-1:0]    int_status,
  output logic [ST_W-1:0]    int_en,
  output logic [31:0]        fifo_status,
  output logic               irq
);
  logic             tx_en, rx_en, ae, af, trail_fire;
  logic [LVL_W-1:0] tx_trig, rx_trig;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [3:0]       ferr;
  irq_vec_t         set_vec, st_q, st_nxt, en_q;
  logic             irq_q;

  fit_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .LEN_W(LEN_W)) u_thresh (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .setup(xfer_setup), .setup_rd(xfer_rd), .setup_len(xfer_len),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_en(tx_en), .rx_en(rx_en), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .almost_empty(ae), .almost_full(af));

  fit_flowerr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flow (
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .err(ferr));

  fit_trail #(.LVL_W(LVL_W), .TRAIL_W(TRAIL_W), .TRAIL_DEF(TRAIL_DEF)) u_trail (
    .clk(clk), .rst_n(rst_n), .lim_wr(trail_wr), .lim_wdata(trail_wdata),
    .rx_en(rx_en), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_push(rx_push), .rx_pop(rx_pop), .fire(trail_fire));

  assign set_vec = {ev_tmo, ev_nodev, ev_nack, ev_abort, ev_done,
                    trail_fire, ferr, af, ae};

  for (genvar i = 0; i < ST_W; i++) begin : g_st
    assign st_nxt[i] = (st_q[i] && !(ist_clr && ist_wdata[i])) || set_vec[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      irq_q <= |(st_q & en_q);
      if (ien_wr) en_q <= ien_wdata;
    end
  end

  assign int_status = st_q;
  assign int_en     = en_q;
  assign irq        = irq_q;

  assign ctrl_rdata = {9'b0, FLD_W'(tx_trig), 5'b0, FLD_W'(rx_trig), 2'b0, tx_en, rx_en};
  assign fifo_status = {7'b0, rx_empty, rx_full, FLD_W'(rx_level),
                        7'b0, tx_empty, tx_full, FLD_W'(tx_level)};

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ist_clr |=> (($past(int_status) & ~int_status) == '0));
  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ist_clr |=> ((int_status & $past(ist_wdata) & ~$past(set_vec)) == '0));
  // R3
  ae_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ae |=> int_status[B_TXAE]);
  // R5
  tx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && (tx_level == LVL_W'(DEPTH))) |=> int_status[B_TXOR]);
  // R6
  done_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> int_status[B_DONE]);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(int_status & int_en)));
endmodule

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ctrl_wr = 0, xfer_setup = 0, xfer_rd = 0, ien_wr = 0, ist_clr = 0, trail_wr = 0;
  logic [31:0] ctrl_wdata = 0;
  logic [15:0] xfer_len = 0;
  logic [11:0] ien_wdata = 0, ist_wdata = 0;
  logic [3:0]  trail_wdata = 0;
  logic [4:0]  tx_level = 0, rx_level = 0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic        ev_done = 0, ev_abort = 0, ev_nack = 0, ev_nodev = 0, ev_tmo = 0;
  logic [31:0] ctrl_rdata, fifo_status, ctrl_rdata64, fifo_status64;
  logic [11:0] int_status, int_en, int_status64, int_en64;
  logic        irq, irq64;

  fifo_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .xfer_setup(xfer_setup), .xfer_rd(xfer_rd), .xfer_len(xfer_len),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ist_clr(ist_clr), .ist_wdata(ist_wdata),
    .trail_wr(trail_wr), .trail_wdata(trail_wdata), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .ev_done(ev_done), .ev_abort(ev_abort), .ev_nack(ev_nack), .ev_nodev(ev_nodev), .ev_tmo(ev_tmo),
    .int_status(int_status), .int_en(int_en), .fifo_status(fifo_status), .irq(irq));

  fifo_irq_ctrl #(.DEPTH(64)) dut64 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata64),
    .xfer_setup(xfer_setup), .xfer_rd(xfer_rd), .xfer_len(xfer_len),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ist_clr(ist_clr), .ist_wdata(ist_wdata),
    .trail_wr(trail_wr), .trail_wdata(trail_wdata), .tx_level(7'(tx_level)), .rx_level(7'(rx_level)),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .ev_done(ev_done), .ev_abort(ev_abort), .ev_nack(ev_nack), .ev_nodev(ev_nodev), .ev_tmo(ev_tmo),
    .int_status(int_status64), .int_en(int_en64), .fifo_status(fifo_status64), .irq(irq64));

  int n_total = 0, n_pass = 0;

  // {tx_level, rx_level, tx_trig, rx_trig, expected {af, ae}}
  localparam logic [29:0] VEC [6] = '{
    {7'd2,  7'd0,  7'd4, 7'd8, 2'b01},
    {7'd4,  7'd8,  7'd4, 7'd8, 2'b11},
    {7'd5,  7'd7,  7'd4, 7'd8, 2'b00},
    {7'd16, 7'd16, 7'd4, 7'd8, 2'b10},
    {7'd0,  7'd1,  7'd0, 7'd1, 2'b11},
    {7'd9,  7'd3,  7'd8, 7'd4, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    ctrl_wr = 1; ctrl_wdata = 0; tick(); ctrl_wr = 0;
    ist_clr = 1; ist_wdata = 12'hFFF; tick(); ist_clr = 0;
  endtask

  task automatic setup(input logic rd, input int len);
    xfer_setup = 1; xfer_rd = rd; xfer_len = 16'(len); tick(); xfer_setup = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 status", 32'(int_status), 0);
    check("R1 enable", 32'(int_en), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 ctrl", ctrl_rdata, 0);
    check("R1 fifo_status", fifo_status, 32'h0100_0100);

    // R3 R9 R10 vector table
    foreach (VEC[i]) begin
      logic [6:0] tl, rl, tt, rt;
      {tl, rl, tt, rt} = VEC[i][29:2];
      tx_level = 5'(tl); rx_level = 5'(rl);
      ctrl_wr = 1; ctrl_wdata = {9'b0, tt, 5'b0, rt, 4'b0011}; tick(); ctrl_wr = 0;
      check("R10 ctrl readback", ctrl_rdata, {9'b0, tt, 5'b0, rt, 4'b0011});
      tick();
      check("R3 watermark", 32'(int_status), 32'(VEC[i][1:0]));
      check("R9 fifo_status", fifo_status,
            {7'b0, rl == 0, rl == 16, rl, 7'b0, tl == 0, tl == 16, tl});
      clear_all();
    end
    tx_level = 0; rx_level = 0;

    // R4 direction-dependent trigger defaults
    setup(1, 20); check("R4 rx long", 32'(ctrl_rdata[10:4]), 12);
    setup(1, 5);  check("R4 rx short", 32'(ctrl_rdata[10:4]), 5);
    setup(0, 20); check("R4 tx long", 32'(ctrl_rdata[22:16]), 4);
    setup(0, 16); check("R4 tx equal", 32'(ctrl_rdata[22:16]), 16);
    setup(1, 100); check("R4 rx long d64", 32'(ctrl_rdata64[10:4]), 48);
    setup(0, 100); check("R4 tx long d64", 32'(ctrl_rdata64[22:16]), 16);
    xfer_setup = 1; xfer_rd = 1; xfer_len = 7; ctrl_wr = 1; ctrl_wdata = 32'h0000_0030; tick();
    xfer_setup = 0; ctrl_wr = 0;
    check("R4 setup priority", 32'(ctrl_rdata[10:4]), 7);
    clear_all();

    // R5 underrun / overrun
    tx_level = 16; tx_push = 1; tick(); tx_push = 0;
    check("R5 tx overrun", 32'(int_status), 32'h008); clear_all();
    tx_level = 15; tx_push = 1; tick(); tx_push = 0;
    check("R5 tx push not full", 32'(int_status), 0); clear_all();
    tx_level = 0; tx_pop = 1; tick(); tx_pop = 0;
    check("R5 tx underrun", 32'(int_status), 32'h004); clear_all();
    rx_level = 16; rx_push = 1; tick(); rx_push = 0;
    check("R5 rx overrun", 32'(int_status), 32'h020); clear_all();
    rx_level = 0; rx_pop = 1; tick(); rx_pop = 0;
    check("R5 rx underrun", 32'(int_status), 32'h010); clear_all();

    // R6 result events, R2 write-one-to-clear
    ev_done = 1; ev_tmo = 1; tick(); ev_done = 0; ev_tmo = 0;
    check("R6 done+tmo", 32'(int_status), 32'h880);
    ev_abort = 1; ev_nodev = 1; tick(); ev_abort = 0; ev_nodev = 0;
    check("R6 abort+nodev", 32'(int_status), 32'h D80);
    ist_clr = 1; ist_wdata = 12'h080; tick(); ist_clr = 0;
    check("R2 partial clear", 32'(int_status), 32'hD00);
    ist_clr = 1; ist_wdata = 12'h200; ev_nack = 1; tick(); ist_clr = 0; ev_nack = 0;
    check("R2 set wins", 32'(int_status), 32'hF00);
    tick(2);
    check("R2 sticky", 32'(int_status), 32'hF00);
    ist_clr = 1; ist_wdata = 12'hFFF; tick(); ist_clr = 0;
    check("R2 full clear", 32'(int_status), 0);

    // R8 registered, masked interrupt
    ien_wr = 1; ien_wdata = 12'h080; tick(); ien_wr = 0;
    ev_done = 1; tick(); ev_done = 0;
    check("R8 status first", 32'(int_status), 32'h080);
    check("R8 irq lag", 32'(irq), 0);
    tick();
    check("R8 irq raised", 32'(irq), 1);
    ist_clr = 1; ist_wdata = 12'hFFF; tick(); ist_clr = 0;
    tick();
    check("R8 irq drops", 32'(irq), 0);
    ev_tmo = 1; tick(); ev_tmo = 0; tick();
    check("R8 masked bit", 32'(irq), 0);
    clear_all();

    // R7 trailing with default limit 15 (R10)
    rx_level = 2;
    ctrl_wr = 1; ctrl_wdata = 32'h0000_0081; tick(); ctrl_wr = 0;
    tick(15);
    check("R7 default not yet", 32'(int_status[6]), 0);
    tick();
    check("R7 default fires", 32'(int_status[6]), 1);
    ist_clr = 1; ist_wdata = 12'h040; tick(); ist_clr = 0;
    tick(3);
    check("R7 once per stretch", 32'(int_status[6]), 0);
    trail_wr = 1; trail_wdata = 3; rx_pop = 1; tick(); trail_wr = 0; rx_pop = 0;
    tick(3);
    check("R7 limit3 not yet", 32'(int_status[6]), 0);
    tick();
    check("R7 limit3 fires", 32'(int_status[6]), 1);
    rx_level = 8;
    ist_clr = 1; ist_wdata = 12'hFFF; tick(); ist_clr = 0;
    tick(6);
    check("R7 at trigger no trail", 32'(int_status[6]), 0);

    finish_run();
  end
endmodule